// File: doc/BRIEF.md
# Shadowed High/Low Count PWM Generator

This block produces one pulse-width-modulated output whose shape is set by two 32-bit cycle counts. One count gives the number of clock cycles the output stays high, and the other gives the number of cycles it stays low. Each period starts with the high phase and lasts high plus low cycles. Software reaches the block through a small word-wide register port. It can write a control word, a high-count register and a low-count register, and it can read each of them back.

Count writes are buffered. They land in shadow registers and leave the running waveform untouched. They take effect only when software writes the control word with its update bit set. That write copies both shadows into the active counts together and restarts the period at the start of the high phase. Software can therefore retune the duty cycle and the period without ever producing a mixed, half-old half-new period. The output toggles only while both the enable bit and the output-enable bit are set. In every other case it is held low.

Top module: `shadow_pwm`

## Requirements
- R1: After reset, all three registers read 0 and `pwm_out` is 0.
- R2: The control word sits at byte offset 0x00, the low count at 0x18 and the high count at 0x1C. Each register reads back the full 32-bit value last written to it. Any other offset reads 0, and writes to other offsets change no register.
- R3: A write to the high-count or low-count register does not alter the running waveform. A control write with bit 5 clear does not alter it either, and it does not restart the period.
- R4: A control write with bit 5 (update) set loads both shadow counts into the active counts on that clock edge. In the cycles after that edge, the output is high for the high count, then low for the low count, and the pattern repeats.
- R5: The output toggles only when control bit 0 (enable) and bit 14 (output enable) are both 1. In every other case it is 0. Writing 0 to the control word forces the output low.
- R6: When both active counts are 0, the output is constantly 0, whatever the invert bit is.
- R7: A high count of 0 with a nonzero low count holds the raw level low. A low count of 0 with a nonzero high count holds the raw level high.
- R8: Control bit 10 (invert) inverts the output level while the generator is enabled. It has no effect while the generator is disabled.
- R9: Control bits 2 and 9 are stored and read back, but they have no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check several properties on every cycle:
- The active counts stay frozen unless an update commit occurs.
- A commit loads the shadow values and restarts the high phase.
- The counter stays inside the current phase.
- The output is low while the generator is gated off or both counts are 0.
- A control write is stored exactly.

Some behaviours can only be shown by the bench's scenarios, because they are judged over many cycles:
- The exact high/low sequence for each count pair and polarity.
- A waveform that keeps running unchanged across shadow writes and non-update control writes.
- Reserved bits that leave the waveform unchanged.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LOW  = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_HIGH = 5'h1C;

    localparam int BIT_EN  = 0;
    localparam int BIT_UPD = 5;
    localparam int BIT_INV = 10;
    localparam int BIT_OEN = 14;

    typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;
endpackage

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs
    import shadow_pwm_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      ctrl_o,
    output logic [W-1:0]      shd_high_o,
    output logic [W-1:0]      shd_low_o,
    output logic              commit_o
);
    typedef struct packed {
        logic [W-1:0] ctrl;
        logic [W-1:0] high;
        logic [W-1:0] low;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            case (addr_i)
                OFS_CTRL: regs_d.ctrl = wdata_i;
                OFS_HIGH: regs_d.high = wdata_i;
                OFS_LOW:  regs_d.low  = wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr_i)
            OFS_CTRL: rdata_o = regs_q.ctrl;
            OFS_HIGH: rdata_o = regs_q.high;
            OFS_LOW:  rdata_o = regs_q.low;
            default:  rdata_o = '0;
        endcase
    end

    assign commit_o   = wr_i && (addr_i == OFS_CTRL) && wdata_i[BIT_UPD];
    assign ctrl_o     = regs_q.ctrl;
    assign shd_high_o = regs_q.high;
    assign shd_low_o  = regs_q.low;

    // R2: a control write is stored exactly
    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_CTRL) |=> (ctrl_o == $past(wdata_i)));
endmodule

// File: rtl/shadow_pwm_phase.sv
module shadow_pwm_phase
    import shadow_pwm_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic         run_i,
    input  logic [W-1:0] shd_high_i,
    input  logic [W-1:0] shd_low_i,
    output logic [W-1:0] act_high_o,
    output logic [W-1:0] act_low_o,
    output logic         level_o
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] high;
        logic [W-1:0] low;
        logic [W-1:0] cnt;
        phase_e       ph;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic hold;

    assign hold = !run_i || (ctr_q.high == '0) || (ctr_q.low == '0);

    always_comb begin
        ctr_d = ctr_q;
        if (commit_i) begin
            ctr_d.high = shd_high_i;
            ctr_d.low  = shd_low_i;
            ctr_d.cnt  = '0;
            ctr_d.ph   = PH_HIGH;
        end else if (hold) begin
            ctr_d.cnt = '0;
            ctr_d.ph  = PH_HIGH;
        end else if (ctr_q.ph == PH_HIGH) begin
            if (ctr_q.cnt == ctr_q.high - ONE) begin
                ctr_d.cnt = '0;
                ctr_d.ph  = PH_LOW;
            end else begin
                ctr_d.cnt = ctr_q.cnt + ONE;
            end
        end else begin
            if (ctr_q.cnt == ctr_q.low - ONE) begin
                ctr_d.cnt = '0;
                ctr_d.ph  = PH_HIGH;
            end else begin
                ctr_d.cnt = ctr_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '{high: '0, low: '0, cnt: '0, ph: PH_HIGH};
        else        ctr_q <= ctr_d;
    end

    always_comb begin
        if (ctr_q.high == '0)     level_o = 1'b0;
        else if (ctr_q.low == '0) level_o = 1'b1;
        else                      level_o = (ctr_q.ph == PH_HIGH);
    end

    assign act_high_o = ctr_q.high;
    assign act_low_o  = ctr_q.low;

    // R3: active counts move only on an update commit
    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(act_high_o) && $stable(act_low_o)));

    // R4: commit loads both shadows and restarts the high phase
    assert_commit_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (act_high_o == $past(shd_high_i) && act_low_o == $past(shd_low_i)
                      && ctr_q.cnt == '0 && ctr_q.ph == PH_HIGH));

    // R4: the counter stays inside the phase it is in
    assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.high != '0 && ctr_q.low != '0) |->
            ((ctr_q.ph == PH_HIGH) ? (ctr_q.cnt < ctr_q.high) : (ctr_q.cnt < ctr_q.low)));
endmodule

// File: rtl/shadow_pwm_gate.sv
module shadow_pwm_gate
    import shadow_pwm_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         oen_i,
    input  logic         inv_i,
    input  logic         level_i,
    input  logic [W-1:0] act_high_i,
    input  logic [W-1:0] act_low_i,
    output logic         pwm_o
);
    logic live;
    logic idle;

    assign live  = en_i && oen_i;
    assign idle  = (act_high_i == '0) && (act_low_i == '0);
    assign pwm_o = live && !idle && (level_i ^ inv_i);

    // R5: gated-off generator drives low
    assert_gate_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && oen_i) |-> !pwm_o);

    // R6: both counts zero drives low
    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_high_i == '0 && act_low_i == '0) |-> !pwm_o);
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
    import shadow_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              pwm_out
);
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] shd_high, shd_low;
    logic [REG_W-1:0] act_high, act_low;
    logic             commit;
    logic             level;
    logic             run;

    assign run = ctrl[BIT_EN] && ctrl[BIT_OEN];

    shadow_pwm_regs #(.W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .ctrl_o     (ctrl),
        .shd_high_o (shd_high),
        .shd_low_o  (shd_low),
        .commit_o   (commit)
    );

    shadow_pwm_phase #(.W(REG_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .run_i      (run),
        .shd_high_i (shd_high),
        .shd_low_i  (shd_low),
        .act_high_o (act_high),
        .act_low_o  (act_low),
        .level_o    (level)
    );

    shadow_pwm_gate #(.W(REG_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl[BIT_EN]),
        .oen_i      (ctrl[BIT_OEN]),
        .inv_i      (ctrl[BIT_INV]),
        .level_i    (level),
        .act_high_i (act_high),
        .act_low_i  (act_low),
        .pwm_o      (pwm_out)
    );
endmodule

// File: tb/tb_shadow_pwm.sv
module tb_shadow_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [31:0] EN  = 32'h0000_0001;
    localparam logic [31:0] UPD = 32'h0000_0020;
    localparam logic [31:0] INV = 32'h0000_0400;
    localparam logic [31:0] OEN = 32'h0000_4000;
    localparam logic [31:0] RSV = 32'h0000_0204;

    // {high[7:0], low[7:0], invert}
    localparam int NV = 9;
    localparam logic [16:0] VECS [0:NV-1] = '{
        {8'd3, 8'd2, 1'b0}, {8'd1, 8'd1, 1'b0}, {8'd4, 8'd1, 1'b1},
        {8'd0, 8'd3, 1'b0}, {8'd0, 8'd3, 1'b1}, {8'd2, 8'd0, 1'b0},
        {8'd0, 8'd0, 1'b0}, {8'd0, 8'd0, 1'b1}, {8'd1, 8'd5, 1'b0}
    };

    always #10 clk = ~clk;

    shadow_pwm dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; takes exactly one cycle
    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic exp_lvl(int hi, int lo, bit inv, int idx);
        if (hi == 0 && lo == 0) return 1'b0;
        if (hi == 0) return inv;
        if (lo == 0) return !inv;
        return ((idx % (hi + lo)) < hi) ^ inv;
    endfunction

    task automatic wave(input string tag, input int hi, input int lo, input bit inv,
                        input int start, input int n);
        for (int i = 0; i < n; i++) begin
            chk(tag, {31'b0, pwm_out}, {31'b0, exp_lvl(hi, lo, inv, start + i)});
            @(negedge clk);
        end
    endtask

    task automatic steady(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            chk(tag, {31'b0, pwm_out}, 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk("R1 ctrl", v, 0);
        rd(5'h18, v); chk("R1 low", v, 0);
        rd(5'h1C, v); chk("R1 high", v, 0);
        chk("R1 out", {31'b0, pwm_out}, 0);
        @(negedge clk);

        // R2 map and readback
        wr(5'h1C, 32'hDEAD_BEEF);
        wr(5'h18, 32'h1234_5678);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h1C, v); chk("R2 high", v, 32'hDEAD_BEEF);
        rd(5'h18, v); chk("R2 low", v, 32'h1234_5678);
        rd(5'h04, v); chk("R2 unmapped", v, 0);
        rd(5'h00, v); chk("R2 ctrl untouched", v, 0);
        @(negedge clk);

        // table walk: R4/R6/R7/R8
        for (int k = 0; k < NV; k++) begin
            int hi, lo, n;
            bit inv;
            string tag;
            hi = int'(VECS[k][16:9]); lo = int'(VECS[k][8:1]); inv = VECS[k][0];
            if (hi == 0 && lo == 0) tag = "R6 both zero";
            else if (hi == 0 || lo == 0) tag = "R7 one zero";
            else if (inv) tag = "R8 invert";
            else tag = "R4 waveform";
            wr(5'h18, 32'(lo));
            wr(5'h1C, 32'(hi));
            wr(5'h00, EN | OEN | UPD | (inv ? INV : 32'h0));
            n = (hi + lo == 0) ? 8 : 2 * (hi + lo) + 3;
            wave(tag, hi, lo, inv, 0, n);
        end

        // R3 shadowing
        wr(5'h18, 32'd2);
        wr(5'h1C, 32'd2);
        wr(5'h00, EN | OEN | UPD);
        wave("R3 base", 2, 2, 0, 0, 4);
        wr(5'h1C, 32'd5);
        wr(5'h18, 32'd5);
        wave("R3 after shadow writes", 2, 2, 0, 6, 8);
        wr(5'h00, EN | OEN);
        wave("R3 ctrl without update", 2, 2, 0, 15, 8);
        rd(5'h1C, v); chk("R3 shadow readback", v, 32'd5);
        wr(5'h00, EN | OEN | UPD);
        wave("R4 commit new counts", 5, 5, 0, 0, 20);

        // R5 gating
        wr(5'h00, EN);
        steady("R5 enable only", 12);
        wr(5'h00, OEN);
        steady("R5 output-enable only", 12);
        wr(5'h00, EN | OEN | UPD);
        wave("R5 running", 5, 5, 0, 0, 3);
        wr(5'h00, 32'h0);
        steady("R5 ctrl zero", 12);

        // R8 invert while disabled
        wr(5'h00, INV | OEN);
        steady("R8 invert disabled", 12);

        // R9 reserved bits
        wr(5'h18, 32'd2);
        wr(5'h1C, 32'd3);
        wr(5'h00, EN | OEN | UPD | RSV);
        wave("R9 reserved no effect", 3, 2, 0, 0, 11);
        rd(5'h00, v); chk("R9 readback", v, EN | OEN | UPD | RSV);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule